// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds eight 80-bit data registers and runs them as a circular stack for a floating-point datapath. A 3-bit top pointer names the physical register that is currently stack slot 0. Stack-relative slot i lives in physical register (top + i) mod 8. Every register carries a 2-bit content tag. The tag encoding is 00 valid, 01 zero, 10 special and 11 empty. The tags are what let the block notice a push into an occupied slot (overflow) or a use of an empty one (underflow).

The surrounding datapath uses four request types, and any of them may appear in the same cycle. A push loads an operand into a new slot 0. A read returns any slot combinationally, for example to fetch operands or to store slot 0 out. A result write replaces a slot's data and tag. A pop discards slot 0. Stores with pop and the no-operand arithmetic forms are expressed as a result write combined with a pop in the same cycle. In that combined case the write index is taken relative to the stack as it stands after the pop.

The push stream is valid/ready. The block never applies back-pressure: push_ready is held high, and a push is consumed in any cycle where push_valid is high. A push that would overflow is still consumed. It is dropped, and its only visible effect is the overflow flag. The other pins are plain level controls that are sampled at each rising clock edge.

Top module: `fpst_stack_ctl`

## Requirements
- R1: After reset, top_o is 0, every tag in tags_o is 11 (empty), and ovf_o and unf_o are 0. tags_o bits [2k+1:2k] hold the tag of physical register k.
- R2: A push whose target register (top - 1) mod 8 is empty has the following effects after the clock edge. top_o becomes (top - 1) mod 8. That register takes push_data and push_tag. Slot 0 then reads back the pushed value.
- R3: A push whose target register is not empty raises ovf_o for exactly the next cycle. It leaves top_o, all tags and all data unchanged.
- R4: rd_data and rd_tag show the data and tag of physical register (top_o + rd_idx) mod 8 in the same cycle, whether or not rd_en is high.
- R5: A pop with slot 0 non-empty sets the tag of the old top register to 11 and advances top_o to (top + 1) mod 8.
- R6: A pop with slot 0 empty raises unf_o for the next cycle and changes nothing. Any result write presented in that cycle is also discarded.
- R7: rd_en high while slot rd_idx is empty raises unf_o for the next cycle. The stack state is unchanged.
- R8: A result write without a pop replaces the data and tag of slot wr_idx, relative to the current top. top_o is unchanged.
- R9: A result write in the same cycle as a successful pop targets physical register (top + 1 + wr_idx) mod 8. With wr_idx 7 this is the register being popped, and in that case the written tag and data take precedence over the empty mark.
- R10: In a cycle with push_valid high, pop_en and wr_en have no effect, whether the push succeeds or overflows.
- R11: push_ready is 1 in every cycle after reset, so no push is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push request, stream valid |
| push_ready | output | 1 | Push stream ready, always high |
| push_data | input | 80 | Operand to push |
| push_tag | input | 2 | Tag stored with the pushed operand |
| pop_en | input | 1 | Discard slot 0 |
| wr_en | input | 1 | Result write request |
| wr_idx | input | 3 | Stack-relative slot to write |
| wr_data | input | 80 | Result data |
| wr_tag | input | 2 | Result tag |
| rd_en | input | 1 | Read is in use; enables the underflow check |
| rd_idx | input | 3 | Stack-relative slot to read |
| rd_data | output | 80 | Data of the selected slot |
| rd_tag | output | 2 | Tag of the selected slot |
| top_o | output | 3 | Current top pointer, for the status word |
| tags_o | output | 16 | Tags of physical registers 0 to 7 |
| ovf_o | output | 1 | One-cycle overflow pulse |
| unf_o | output | 1 | One-cycle underflow pulse |

## Verification
The bench targets each point where the pointer wraps. It fills all eight registers and then pushes a ninth value. A design that skips the tag check at that point would overwrite the oldest entry and move the pointer. It then pops one entry past empty, and a faulty design there would walk the pointer into stale data. Combined pop-and-write cycles are run with index 0 and index 7: a design that decodes the write against the pre-pop pointer lands one slot off, and one that lets the empty mark win loses the result. Push cycles that also carry pop and write requests, plus long random mixes, expose any leakage between requests or any mistake in the modulo arithmetic.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;
endpackage

// File: rtl/fpst_top_ptr.sv
module fpst_top_ptr #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [PW-1:0] top_o
);
  localparam logic [PW-1:0] ONE = 1;
  logic [PW-1:0] top_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     top_q <= '0;
    else if (dec_i) top_q <= top_q - ONE;
    else if (inc_i) top_q <= top_q + ONE;
  end

  assign top_o = top_q;
endmodule

// File: rtl/fpst_tag_file.sv
module fpst_tag_file #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [PW-1:0]   push_slot,
  input  logic [1:0]      push_tag,
  input  logic            clr_en,
  input  logic [PW-1:0]   clr_slot,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_slot,
  input  logic [1:0]      wr_tag,
  output logic [2*N-1:0]  tags_o
);
  import fpst_pkg::*;

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic [1:0] tag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= TAG_EMPTY;
      else if (wr_en && wr_slot == PW'(k))     tag_q <= wr_tag;
      else if (push_en && push_slot == PW'(k)) tag_q <= push_tag;
      else if (clr_en && clr_slot == PW'(k))   tag_q <= TAG_EMPTY;
    end
    assign tags_o[2*k +: 2] = tag_q;
  end
endmodule

// File: rtl/fpst_data_file.sv
module fpst_data_file #(
  parameter int N  = 8,
  parameter int DW = 80,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [PW-1:0] push_slot,
  input  logic [DW-1:0] push_data,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_slot,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] ent [N];

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[k] <= '0;
      else if (wr_en && wr_slot == PW'(k))     ent[k] <= wr_data;
      else if (push_en && push_slot == PW'(k)) ent[k] <= push_data;
    end
  end

  assign rd_data = ent[rd_slot];
endmodule

// File: rtl/fpst_stack_ctl.sv
module fpst_stack_ctl #(
  parameter int N  = 8,
  parameter int DW = 80,
  parameter int PW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  output logic            push_ready,
  input  logic [DW-1:0]   push_data,
  input  logic [1:0]      push_tag,
  input  logic            pop_en,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      wr_tag,
  input  logic            rd_en,
  input  logic [PW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [1:0]      rd_tag,
  output logic [PW-1:0]   top_o,
  output logic [2*N-1:0]  tags_o,
  output logic            ovf_o,
  output logic            unf_o
);
  import fpst_pkg::*;
  localparam logic [PW-1:0] ONE = 1;

  logic [PW-1:0] top, push_slot, rd_slot, wr_base, wr_slot;
  logic [1:0]    tag_arr [N];
  logic          push_fire, push_ok, push_ovf;
  logic          pop_req, pop_uf, pop_ok, wr_ok, rd_uf;
  logic          ovf_q, unf_q;

  for (genvar k = 0; k < N; k++) begin : g_unpack
    assign tag_arr[k] = tags_o[2*k +: 2];
  end

  assign push_ready = 1'b1;
  assign push_fire  = push_valid && push_ready;
  assign push_slot  = top - ONE;
  assign push_ovf   = push_fire && (tag_arr[push_slot] != TAG_EMPTY);
  assign push_ok    = push_fire && !push_ovf;

  assign pop_req = pop_en && !push_fire;
  assign pop_uf  = pop_req && (tag_arr[top] == TAG_EMPTY);
  assign pop_ok  = pop_req && !pop_uf;

  assign wr_ok   = wr_en && !push_fire && !pop_uf;
  assign wr_base = pop_ok ? top + ONE : top;
  assign wr_slot = wr_base + wr_idx;

  assign rd_slot = top + rd_idx;
  assign rd_uf   = rd_en && (tag_arr[rd_slot] == TAG_EMPTY);
  assign rd_tag  = tag_arr[rd_slot];

  fpst_top_ptr #(.PW(PW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .dec_i (push_ok),
    .inc_i (pop_ok),
    .top_o (top)
  );

  fpst_tag_file #(.N(N), .PW(PW)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_ok),
    .push_slot (push_slot),
    .push_tag  (push_tag),
    .clr_en    (pop_ok),
    .clr_slot  (top),
    .wr_en     (wr_ok),
    .wr_slot   (wr_slot),
    .wr_tag    (wr_tag),
    .tags_o    (tags_o)
  );

  fpst_data_file #(.N(N), .DW(DW), .PW(PW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_ok),
    .push_slot (push_slot),
    .push_data (push_data),
    .wr_en     (wr_ok),
    .wr_slot   (wr_slot),
    .wr_data   (wr_data),
    .rd_slot   (rd_slot),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= push_ovf;
      unf_q <= pop_uf || rd_uf;
    end
  end

  assign top_o = top;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/fpst_stack_chk.sv
module fpst_stack_chk #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           push_valid,
  input logic           push_ready,
  input logic           pop_en,
  input logic           rd_en,
  input logic [PW-1:0]  rd_idx,
  input logic [PW-1:0]  top_o,
  input logic [2*N-1:0] tags_o,
  input logic           ovf_o,
  input logic           unf_o
);
  localparam logic [PW-1:0] ONE = 1;

  function automatic logic [1:0] tag_at(input logic [2*N-1:0] t, input logic [PW-1:0] i);
    return t[2*i +: 2];
  endfunction

  logic below_full, top_empty, rd_empty;
  assign below_full = tag_at(tags_o, top_o - ONE) != 2'b11;
  assign top_empty  = tag_at(tags_o, top_o) == 2'b11;
  assign rd_empty   = tag_at(tags_o, top_o + rd_idx) == 2'b11;

  p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !below_full |=> top_o == $past(top_o) - ONE);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && below_full |=> ovf_o && $stable(top_o) && $stable(tags_o));

  p_ovf_only_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |=> !ovf_o);

  p_pop_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid && pop_en && !top_empty |=> top_o == $past(top_o) + ONE);

  p_pop_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid && pop_en && top_empty |=> unf_o && $stable(top_o) && $stable(tags_o));

  p_read_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_empty |=> unf_o);

  p_ready_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready);
endmodule

bind fpst_stack_ctl fpst_stack_chk #(.N(N), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .pop_en     (pop_en),
  .rd_en      (rd_en),
  .rd_idx     (rd_idx),
  .top_o      (top_o),
  .tags_o     (tags_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/tb_fpst_stack_ctl.sv
module tb_fpst_stack_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, pop_en = 0, wr_en = 0, rd_en = 0;
  logic        push_ready;
  logic [79:0] push_data = '0, wr_data = '0, rd_data;
  logic [1:0]  push_tag = '0, wr_tag = '0, rd_tag;
  logic [2:0]  wr_idx = '0, rd_idx = '0, top_o;
  logic [15:0] tags_o;
  logic        ovf_o, unf_o;

  always #2 clk = ~clk;

  fpst_stack_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data), .push_tag(push_tag),
    .pop_en(pop_en), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag),
    .top_o(top_o), .tags_o(tags_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  int vectors = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [79:0] m_data [8];
  logic [1:0]  m_tag  [8];
  logic [2:0]  m_top;
  bit          e_ovf, e_unf;

  function automatic logic [15:0] m_tags_flat();
    logic [15:0] f;
    for (int k = 0; k < 8; k++) f[2*k +: 2] = m_tag[k];
    return f;
  endfunction

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), 16'($urandom())};
  endfunction

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit pv, input logic [79:0] pd, input logic [1:0] pt,
                      input bit pe, input bit we, input logic [2:0] wi,
                      input logic [79:0] wd, input logic [1:0] wt,
                      input bit re, input logic [2:0] ri);
    string req;
    logic [2:0] ps, rs, ws;
    bit ovf, puf, ruf, pok;
    push_valid = pv; push_data = pd; push_tag = pt; pop_en = pe;
    wr_en = we; wr_idx = wi; wr_data = wd; wr_tag = wt; rd_en = re; rd_idx = ri;
    #1;
    rs = m_top + ri;
    chk("R4", "rd_data", rd_data, m_data[rs]);
    chk("R4", "rd_tag", {78'd0, rd_tag}, {78'd0, m_tag[rs]});
    chk("R11", "push_ready", {79'd0, push_ready}, 80'd1);
    ps  = m_top - 3'd1;
    ovf = pv && m_tag[ps] != 2'b11;
    puf = !pv && pe && m_tag[m_top] == 2'b11;
    pok = !pv && pe && !puf;
    ruf = re && m_tag[rs] == 2'b11;
    if (pv)       req = (pe || we) ? "R10" : (ovf ? "R3" : "R2");
    else if (puf) req = "R6";
    else if (pok) req = we ? "R9" : "R5";
    else if (we)  req = "R8";
    else if (ruf) req = "R7";
    else          req = "R4";
    if (pv) begin
      if (!ovf) begin
        m_data[ps] = pd; m_tag[ps] = pt; m_top = ps;
      end
    end else if (!puf) begin
      if (pok) begin
        m_tag[m_top] = 2'b11;
        m_top = m_top + 3'd1;
      end
      if (we) begin
        ws = m_top + wi;
        m_data[ws] = wd; m_tag[ws] = wt;
      end
    end
    e_ovf = ovf;
    e_unf = puf || ruf;
    @(negedge clk);
    chk(req, "top_o", {77'd0, top_o}, {77'd0, m_top});
    chk(req, "tags_o", {64'd0, tags_o}, {64'd0, m_tags_flat()});
    chk(req, "ovf_o", {79'd0, ovf_o}, {79'd0, e_ovf});
    chk(req, "unf_o", {79'd0, unf_o}, {79'd0, e_unf});
  endtask

  task automatic idle();
    step(0, '0, 2'b00, 0, 0, 3'd0, '0, 2'b00, 0, 3'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int k = 0; k < 8; k++) begin m_data[k] = '0; m_tag[k] = 2'b11; end
    m_top = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "top_o", {77'd0, top_o}, 80'd0);
    chk("R1", "tags_o", {64'd0, tags_o}, {64'd0, 16'hFFFF});
    chk("R1", "ovf_o", {79'd0, ovf_o}, 80'd0);
    chk("R1", "unf_o", {79'd0, unf_o}, 80'd0);

    // R2 fill, then R3 overflow on the ninth push
    for (int i = 0; i < 8; i++) step(1, rnd80(), 2'(i % 3), 0, 0, 3'd0, '0, 2'b00, 1, 3'd0);
    step(1, rnd80(), 2'b00, 0, 0, 3'd0, '0, 2'b00, 0, 3'd0);
    // R4 read deep slot, R8 write slot 2
    step(0, '0, 2'b00, 0, 0, 3'd0, '0, 2'b00, 1, 3'd7);
    step(0, '0, 2'b00, 0, 1, 3'd2, rnd80(), 2'b10, 0, 3'd2);
    // R10 push overflowing while pop/write asserted
    step(1, rnd80(), 2'b00, 1, 1, 3'd1, rnd80(), 2'b01, 0, 3'd0);
    // R5 pop, then R10 push with pop/write asserted
    step(0, '0, 2'b00, 1, 0, 3'd0, '0, 2'b00, 0, 3'd0);
    step(1, rnd80(), 2'b01, 1, 1, 3'd3, rnd80(), 2'b10, 1, 3'd0);
    // R9 pop with write to new slot 0, and with index 7 (popped register)
    step(0, '0, 2'b00, 1, 1, 3'd0, rnd80(), 2'b00, 1, 3'd0);
    step(0, '0, 2'b00, 1, 1, 3'd7, rnd80(), 2'b10, 1, 3'd7);
    // R5 drain, R6 pop past empty with write discarded, R7 read of empty
    for (int i = 0; i < 10; i++) step(0, '0, 2'b00, 1, 0, 3'd0, '0, 2'b00, 0, 3'd0);
    step(0, '0, 2'b00, 1, 1, 3'd0, rnd80(), 2'b00, 0, 3'd0);
    step(0, '0, 2'b00, 0, 0, 3'd0, '0, 2'b00, 1, 3'd4);
    idle();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 35, rnd80(), 2'($urandom_range(0, 2)),
           ($urandom_range(0, 99) < 35), ($urandom_range(0, 99) < 35),
           3'($urandom_range(0, 7)), rnd80(), 2'($urandom_range(0, 3)),
           ($urandom_range(0, 1) == 1), 3'($urandom_range(0, 7)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule